// File: doc/BRIEF.md
# ADC Input Selection Register with End-of-Conversion Update

This block holds the control byte that steers an ADC front end: the reference selection, the result alignment and the channel/gain selection. A second, narrower write port supplies one extra reference bit and one extra channel bit that extend the two codes to 3 and 6 bits. Software writes both ports at any time. The converter, however, works from an active copy of the codes. That copy is frozen while a conversion runs and refreshed at the edge that ends it.

The block also times each conversion by counting ADC clock enables. A conversion normally spans 13 enabled ticks. When the active reference has changed since the previous start, the next conversion spans 25 ticks. A stub stands in for the analog converter and captures a 10-bit sample input at the final tick. The alignment bit acts on the read path only, so it reshapes the presented 16-bit result word at once, even while a conversion runs.

Top module: `adc_mux_ctrl`

## Requirements
- R1: After reset, rd_data, rd_ext, act_ref, act_chan, ref_kind, result_word, busy and conv_done are all zero.
- R2: A write with wr_en stores wr_data, which reads back on rd_data from the next cycle. Its layout is: bits 7:6 are the low two reference bits, bit 5 is the left-align flag and bits 4:0 are the low five channel bits. A write with ext_wr_en stores ext_wr_data, where bit 1 is reference bit 2 and bit 0 is channel bit 5. It reads back on rd_ext.
- R3: While busy is high, act_ref and act_chan hold their values. They take the programmed codes at the edge that completes the conversion. While idle, they follow the programmed codes one cycle after the register changes.
- R4: A start pulse taken while idle raises busy. After 13 clock edges with adc_clk_en high, busy falls and conv_done is high for exactly one cycle.
- R5: If act_ref has changed value since the previous accepted start, the next conversion lasts 25 enabled ticks instead. Rewriting an unchanged reference code does not lengthen it.
- R6: At the final tick the stub captures sample_in. With left-align clear, result_word presents the sample in bits 9:0, and bits 15:10 are zero.
- R7: With left-align set, result_word presents the sample in bits 15:6, and bits 5:0 are zero. A change of the flag reshapes result_word in the cycle after the write, even during a conversion.
- R8: ref_kind decodes act_ref as follows: codes 0 and 4 give 0 (supply); codes 1 and 5 give 1 (external pin); code 2 gives 2 (internal low); code 6 gives 3 (internal high, no capacitor); code 7 gives 4 (internal high with capacitor); code 3 gives 7.
- R9: ref_invalid is high exactly when the programmed 3-bit reference code, as shown on rd_ext and rd_data, equals 3. The code is still stored and reads back as written.
- R10: temp_sense is high when act_chan equals 11. offset_meas is high when act_chan bit 5 is set and bits 3:2 equal bits 1:0, meaning both differential inputs are the same pin.
- R11: A start pulse during a conversion is ignored, and the running conversion keeps its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte to store |
| ext_wr_en | input | 1 | Write strobe for the extension bits |
| ext_wr_data | input | 2 | {reference bit 2, channel bit 5} |
| rd_data | output | 8 | Stored control byte |
| rd_ext | output | 2 | Stored extension bits |
| start | input | 1 | Conversion request |
| adc_clk_en | input | 1 | ADC clock enable; one conversion tick per high cycle |
| sample_in | input | 10 | Sample delivered to the converter stub |
| busy | output | 1 | Conversion in progress |
| conv_done | output | 1 | One-cycle completion pulse |
| act_ref | output | 3 | Active reference code |
| act_chan | output | 6 | Active channel/gain code |
| ref_kind | output | 3 | Decoded reference kind |
| ref_invalid | output | 1 | Programmed reference code is reserved |
| offset_meas | output | 1 | Active channel is a same-pin differential pair |
| temp_sense | output | 1 | Active channel is the temperature sensor |
| result_word | output | 16 | Aligned conversion result |

## Verification
On every cycle the assertions check four things. The active codes stay frozen inside a conversion. The completion pulse lasts one cycle and leaves busy low. Every conversion ends after exactly 13 or 25 enabled ticks. The padding bits of the result word are zero for the current alignment. Whether a given conversion should have been the long one depends on the history of reference changes. The bench scenarios alone show that, together with the immediate realignment of an old result in mid-conversion and the exact decode of every channel and reference code.

// File: rtl/adc_mux_pkg.sv
package adc_mux_pkg;

   localparam int CTRL_W  = 8;
   localparam int EXT_W   = 2;
   localparam int REF_W   = 3;
   localparam int CHAN_W  = 6;
   localparam int TEMP_CODE = 11;

   typedef enum logic [2:0] {
      REF_SUPPLY       = 3'd0,
      REF_EXT_PIN      = 3'd1,
      REF_INT_LOW      = 3'd2,
      REF_INT_HIGH     = 3'd3,
      REF_INT_HIGH_CAP = 3'd4,
      REF_RESERVED     = 3'd7
   } ref_kind_e;

   typedef struct packed {
      logic [1:0] ref_lo;
      logic       left;
      logic [4:0] chan_lo;
   } ctrl_reg_t;

   typedef struct packed {
      logic [REF_W-1:0]  ref_code;
      logic [CHAN_W-1:0] chan_code;
   } mux_sel_t;

   function automatic ref_kind_e decode_ref(input logic [REF_W-1:0] code);
      ref_kind_e k;
      case (code[1:0])
         2'b00:   k = REF_SUPPLY;
         2'b01:   k = REF_EXT_PIN;
         2'b10:   k = code[2] ? REF_INT_HIGH : REF_INT_LOW;
         default: k = code[2] ? REF_INT_HIGH_CAP : REF_RESERVED;
      endcase
      return k;
   endfunction

   function automatic logic is_temp(input logic [CHAN_W-1:0] code);
      return code == CHAN_W'(TEMP_CODE);
   endfunction

   function automatic logic is_offset(input logic [CHAN_W-1:0] code);
      return code[5] && (code[3:2] == code[1:0]);
   endfunction

endpackage

// File: rtl/amux_regfile.sv
module amux_regfile
   import adc_mux_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   input  logic             ext_wr_en,
   input  logic [EXT_W-1:0] ext_wr_data,
   output ctrl_reg_t        ctrl_q,
   output logic [EXT_W-1:0] ext_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         ext_q  <= '0;
      end else begin
         if (wr_en)     ctrl_q <= ctrl_reg_t'(wr_data);
         if (ext_wr_en) ext_q  <= ext_wr_data;
      end
   end

endmodule

// File: rtl/amux_shadow.sv
module amux_shadow
   import adc_mux_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  mux_sel_t prog,
   input  logic     load,
   input  logic     take_long,
   output mux_sel_t act,
   output logic     long_pending
);

   logic ref_moves;
   assign ref_moves = load && (prog.ref_code != act.ref_code);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act          <= '0;
         long_pending <= 1'b0;
      end else begin
         if (load) act <= prog;
         if (ref_moves)      long_pending <= 1'b1;
         else if (take_long) long_pending <= 1'b0;
      end
   end

endmodule

// File: rtl/amux_conv_seq.sv
module amux_conv_seq #(
   parameter int NORMAL_CYC = 13,
   parameter int LONG_CYC   = 25
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic adc_clk_en,
   input  logic long_req,
   output logic start_acc,
   output logic finish,
   output logic busy,
   output logic conv_done
);

   localparam int CNT_W = $clog2(LONG_CYC + 1);
   localparam logic [CNT_W-1:0] LAST_NORMAL = CNT_W'(NORMAL_CYC - 1);
   localparam logic [CNT_W-1:0] LAST_LONG   = CNT_W'(LONG_CYC - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_q;

   assign start_acc = start && !busy;
   assign finish    = busy && adc_clk_en && (cnt_q == last_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         cnt_q     <= '0;
         last_q    <= '0;
         conv_done <= 1'b0;
      end else begin
         conv_done <= finish;
         if (start_acc) begin
            busy   <= 1'b1;
            cnt_q  <= '0;
            last_q <= long_req ? LAST_LONG : LAST_NORMAL;
         end else if (busy && adc_clk_en) begin
            if (cnt_q == last_q) busy  <= 1'b0;
            else                 cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/amux_adc_stub.sv
module amux_adc_stub #(
   parameter int SAMPLE_W = 10,
   parameter int DATA_W   = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                capture,
   input  logic [SAMPLE_W-1:0] sample_in,
   input  logic                left,
   output logic [DATA_W-1:0]   word
);

   localparam int PAD_W = DATA_W - SAMPLE_W;

   logic [SAMPLE_W-1:0] samp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       samp_q <= '0;
      else if (capture) samp_q <= sample_in;
   end

   generate
      if (PAD_W == 0) begin : g_flat
         logic unused_left;
         assign unused_left = left;
         assign word = samp_q;
      end else begin : g_pad
         assign word = left ? {samp_q, {PAD_W{1'b0}}}
                            : {{PAD_W{1'b0}}, samp_q};
      end
   endgenerate

endmodule

// File: rtl/adc_mux_ctrl.sv
module adc_mux_ctrl
   import adc_mux_pkg::*;
#(
   parameter int SAMPLE_W   = 10,
   parameter int DATA_W     = 16,
   parameter int NORMAL_CYC = 13,
   parameter int LONG_CYC   = 25
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [CTRL_W-1:0]   wr_data,
   input  logic                ext_wr_en,
   input  logic [EXT_W-1:0]    ext_wr_data,
   output logic [CTRL_W-1:0]   rd_data,
   output logic [EXT_W-1:0]    rd_ext,
   input  logic                start,
   input  logic                adc_clk_en,
   input  logic [SAMPLE_W-1:0] sample_in,
   output logic                busy,
   output logic                conv_done,
   output logic [REF_W-1:0]    act_ref,
   output logic [CHAN_W-1:0]   act_chan,
   output logic [2:0]          ref_kind,
   output logic                ref_invalid,
   output logic                offset_meas,
   output logic                temp_sense,
   output logic [DATA_W-1:0]   result_word
);

   generate
      if (DATA_W < SAMPLE_W) begin : g_bad_width
         $error("result word narrower than sample");
      end
      if (NORMAL_CYC < 2) begin : g_bad_normal
         $error("normal conversion too short");
      end
      if (LONG_CYC <= NORMAL_CYC) begin : g_bad_long
         $error("long conversion must exceed normal");
      end
   endgenerate

   ctrl_reg_t        ctrl_q;
   logic [EXT_W-1:0] ext_q;
   mux_sel_t         prog_sel;
   mux_sel_t         act_sel;
   logic             long_pending;
   logic             start_acc;
   logic             finish;
   logic             shadow_load;
   logic             align_left;

   amux_regfile u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .ext_wr_en  (ext_wr_en),
      .ext_wr_data(ext_wr_data),
      .ctrl_q     (ctrl_q),
      .ext_q      (ext_q)
   );

   assign prog_sel.ref_code  = {ext_q[1], ctrl_q.ref_lo};
   assign prog_sel.chan_code = {ext_q[0], ctrl_q.chan_lo};
   assign align_left         = ctrl_q.left;

   amux_conv_seq #(
      .NORMAL_CYC(NORMAL_CYC),
      .LONG_CYC  (LONG_CYC)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .adc_clk_en(adc_clk_en),
      .long_req  (long_pending),
      .start_acc (start_acc),
      .finish    (finish),
      .busy      (busy),
      .conv_done (conv_done)
   );

   assign shadow_load = (!busy && !start_acc) || finish;

   amux_shadow u_shadow (
      .clk         (clk),
      .rst_n       (rst_n),
      .prog        (prog_sel),
      .load        (shadow_load),
      .take_long   (start_acc),
      .act         (act_sel),
      .long_pending(long_pending)
   );

   amux_adc_stub #(
      .SAMPLE_W(SAMPLE_W),
      .DATA_W  (DATA_W)
   ) u_stub (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (finish),
      .sample_in(sample_in),
      .left     (align_left),
      .word     (result_word)
   );

   assign rd_data     = ctrl_q;
   assign rd_ext      = ext_q;
   assign act_ref     = act_sel.ref_code;
   assign act_chan    = act_sel.chan_code;
   assign ref_kind    = decode_ref(act_sel.ref_code);
   assign ref_invalid = (prog_sel.ref_code == 3'b011);
   assign offset_meas = is_offset(act_sel.chan_code);
   assign temp_sense  = is_temp(act_sel.chan_code);

endmodule

// File: rtl/adc_mux_ctrl_chk.sv
module adc_mux_ctrl_chk
   import adc_mux_pkg::*;
#(
   parameter int SAMPLE_W   = 10,
   parameter int DATA_W     = 16,
   parameter int NORMAL_CYC = 13,
   parameter int LONG_CYC   = 25
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input logic                adc_clk_en,
   input logic                busy,
   input logic                conv_done,
   input logic [REF_W-1:0]    act_ref,
   input logic [CHAN_W-1:0]   act_chan,
   input logic                align_left,
   input logic [DATA_W-1:0]   result_word
);

   localparam int TK_W = $clog2(LONG_CYC + 2);

   logic [TK_W-1:0] ticks;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 ticks <= '0;
      else if (start && !busy)    ticks <= '0;
      else if (busy && adc_clk_en) ticks <= ticks + 1'b1;
   end

   // R3: active codes frozen inside a conversion
   p_hold_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (conv_done || ($stable(act_ref) && $stable(act_chan))));

   // R4: completion pulse is one cycle wide
   p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |=> !conv_done);

   // R4: completion leaves the block idle
   p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |-> !busy);

   // R4 / R5: conversion spans one of the two allowed tick counts
   p_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |-> ((ticks == TK_W'(NORMAL_CYC)) || (ticks == TK_W'(LONG_CYC))));

   // R11: an accepted start raises busy
   p_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   generate
      if (DATA_W > SAMPLE_W) begin : g_pad_chk
         // R7: left alignment clears the low padding
         p_left_pad_r7: assert property (@(posedge clk) disable iff (!rst_n)
            align_left |-> (result_word[DATA_W-SAMPLE_W-1:0] == '0));
         // R6: right alignment clears the high padding
         p_right_pad_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !align_left |-> (result_word[DATA_W-1:SAMPLE_W] == '0));
      end
   endgenerate

endmodule

bind adc_mux_ctrl adc_mux_ctrl_chk #(
   .SAMPLE_W  (SAMPLE_W),
   .DATA_W    (DATA_W),
   .NORMAL_CYC(NORMAL_CYC),
   .LONG_CYC  (LONG_CYC)
) u_chk (.*);

// File: tb/adc_mux_ctrl_tb.sv
module adc_mux_ctrl_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_data = '0;
   logic        ext_wr_en = 1'b0;
   logic [1:0]  ext_wr_data = '0;
   logic [7:0]  rd_data;
   logic [1:0]  rd_ext;
   logic        start = 1'b0;
   logic        adc_clk_en = 1'b0;
   logic [9:0]  sample_in = '0;
   logic        busy;
   logic        conv_done;
   logic [2:0]  act_ref;
   logic [5:0]  act_chan;
   logic [2:0]  ref_kind;
   logic        ref_invalid;
   logic        offset_meas;
   logic        temp_sense;
   logic [15:0] result_word;

   int n_checks = 0;
   int n_errors = 0;
   logic [7:0]  mid_rd;
   logic [2:0]  mid_ref;
   logic [5:0]  mid_chan;
   logic [15:0] mid_word;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_mux_ctrl u_dut (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_data(wr_data),
      .ext_wr_en(ext_wr_en), .ext_wr_data(ext_wr_data),
      .rd_data(rd_data), .rd_ext(rd_ext),
      .start(start), .adc_clk_en(adc_clk_en), .sample_in(sample_in),
      .busy(busy), .conv_done(conv_done),
      .act_ref(act_ref), .act_chan(act_chan), .ref_kind(ref_kind),
      .ref_invalid(ref_invalid), .offset_meas(offset_meas),
      .temp_sense(temp_sense), .result_word(result_word)
   );

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic write_ctrl(input logic [7:0] b);
      @(negedge clk);
      wr_en = 1'b1; wr_data = b;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic write_ext(input logic [1:0] b);
      @(negedge clk);
      ext_wr_en = 1'b1; ext_wr_data = b;
      @(negedge clk);
      ext_wr_en = 1'b0;
   endtask

   function automatic logic [2:0] exp_kind(input logic [2:0] c);
      case (c)
         3'd0, 3'd4: return 3'd0;
         3'd1, 3'd5: return 3'd1;
         3'd2:       return 3'd2;
         3'd6:       return 3'd3;
         3'd7:       return 3'd4;
         default:    return 3'd7;
      endcase
   endfunction

   // one conversion; returns enabled ticks counted while busy
   task automatic conv(input int div, input int hook_at, input logic hook_wr,
                       input logic [7:0] hook_byte, input logic hook_start,
                       output int ticks);
      int phase;
      logic was_busy;
      ticks = 0;
      phase = 0;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int n = 0; n < 4000; n++) begin
         if (conv_done) break;
         if (phase == hook_at + 1) begin
            mid_rd = rd_data; mid_ref = act_ref;
            mid_chan = act_chan; mid_word = result_word;
         end
         wr_en   = (phase == hook_at) && hook_wr;
         wr_data = hook_byte;
         start   = (phase == hook_at) && hook_start;
         adc_clk_en = ((phase % div) == 0);
         phase++;
         was_busy = busy;
         @(negedge clk);
         if (adc_clk_en && was_busy) ticks++;
      end
      adc_clk_en = 1'b0; wr_en = 1'b0; start = 1'b0;
      chk("R4 busy low at done", busy, 0);
      @(negedge clk);
      chk("R4 done pulse width", conv_done, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      int t;
      logic [9:0] last_s;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 rd_data", rd_data, 0);
      chk("R1 rd_ext", rd_ext, 0);
      chk("R1 act_ref", act_ref, 0);
      chk("R1 act_chan", act_chan, 0);
      chk("R1 ref_kind", ref_kind, 0);
      chk("R1 result", result_word, 0);
      chk("R1 busy", busy, 0);
      chk("R1 done", conv_done, 0);

      // R10 / R2 / R3 channel sweep while idle
      for (int c = 0; c < 64; c++) begin
         logic [5:0] cc;
         cc = 6'(c);
         write_ext({1'b0, cc[5]});
         write_ctrl({3'b000, cc[4:0]});
         chk("R2 rd_data", rd_data, {3'b000, cc[4:0]});
         chk("R2 rd_ext", rd_ext, {1'b0, cc[5]});
         @(negedge clk);
         chk("R3 act_chan idle follow", act_chan, cc);
         chk("R10 temp_sense", temp_sense, (c == 11));
         chk("R10 offset_meas", offset_meas, (cc[5] && cc[3:2] == cc[1:0]));
      end

      // R8 / R9 reference sweep
      for (int r = 0; r < 8; r++) begin
         logic [2:0] rc;
         rc = 3'(r);
         write_ext({rc[2], 1'b0});
         write_ctrl({rc[1:0], 6'b0});
         chk("R9 ref_invalid immediate", ref_invalid, (r == 3));
         chk("R9 stored as written", {rd_ext[1], rd_data[7:6]}, rc);
         @(negedge clk);
         chk("R3 act_ref idle follow", act_ref, rc);
         chk("R8 ref_kind", ref_kind, exp_kind(rc));
      end

      // R4 / R5 / R6 lengths and capture (ref now 7, changed)
      sample_in = 10'h3FF;
      conv(1, -5, 1'b0, 8'h00, 1'b0, t);
      chk("R5 long after ref change", t, 25);
      chk("R6 right aligned", result_word, 16'h03FF);
      sample_in = 10'h155;
      conv(1, -5, 1'b0, 8'h00, 1'b0, t);
      chk("R4 normal length", t, 13);
      chk("R6 right aligned", result_word, 16'h0155);
      write_ctrl(8'hC0);
      @(negedge clk);
      sample_in = 10'h2AA;
      conv(3, -5, 1'b0, 8'h00, 1'b0, t);
      chk("R5 same ref rewrite stays normal", t, 13);
      chk("R6 right aligned", result_word, 16'h02AA);
      write_ctrl(8'h80);
      @(negedge clk);
      conv(2, -5, 1'b0, 8'h00, 1'b0, t);
      chk("R5 long after ref 7->6", t, 25);
      conv(1, -5, 1'b0, 8'h00, 1'b0, t);
      chk("R4 normal after long", t, 13);

      // R3 deferral during a conversion
      write_ext(2'b00);
      write_ctrl(8'h00);
      @(negedge clk);
      conv(1, -5, 1'b0, 8'h00, 1'b0, t);
      chk("R5 long after ref 6->0", t, 25);
      conv(2, 4, 1'b1, 8'h4B, 1'b0, t);
      chk("R2 mid readback", mid_rd, 8'h4B);
      chk("R3 mid act_ref held", mid_ref, 0);
      chk("R3 mid act_chan held", mid_chan, 0);
      chk("R4 length with mid write", t, 13);
      chk("R3 act_ref after done", act_ref, 3'd1);
      chk("R3 act_chan after done", act_chan, 6'd11);
      chk("R10 temp after done", temp_sense, 1);
      chk("R8 ext pin kind", ref_kind, 3'd1);
      conv(1, -5, 1'b0, 8'h00, 1'b0, t);
      chk("R5 long after deferred ref change", t, 25);

      // R11 start during conversion ignored
      sample_in = 10'h0F0;
      conv(1, 5, 1'b0, 8'h00, 1'b1, t);
      chk("R11 restart ignored length", t, 13);
      chk("R6 result", result_word, 16'h00F0);
      last_s = 10'h0F0;

      // R7 alignment sweep with mid-conversion flips
      for (int i = 0; i < 12; i++) begin
         logic [9:0] s;
         s = 10'((i * 203 + 17) % 1024);
         sample_in = s;
         conv(1, 3, 1'b1, 8'h6B, 1'b0, t);
         chk("R7 mid realign old result", mid_word, {last_s, 6'b0});
         chk("R4 length in sweep", t, 13);
         chk("R7 left aligned new result", result_word, {s, 6'b0});
         write_ctrl(8'h4B);
         chk("R7 immediate right realign", result_word, {6'b0, s});
         last_s = s;
      end

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule